// File: doc/BRIEF.md
# Ping-pong bit-order reverser

This block sits behind a trellis traceback stage that produces decoded bits newest-first, in bursts of 32. It collects each burst serially and plays it back with the bit order reversed, so the stream that leaves it is in the order the bits were first sent. Two 32-bit banks take turns. One bank fills while the other drains, and a one-bit bank selector flips whenever a full block has been captured and the draining bank is free. With a continuous input stream the output therefore runs continuously, one block behind the input.

The write side takes a bit on every cycle where `in_valid` is high and `stall` is low. The first bit of a block lands in position 31 and the last in position 0. The read side steps from position 0 to position 31, so the bit captured last leaves first. A downstream `stall` freezes both pointers: input bits offered during a stall are not taken, and no output is produced.

The read controller has two states. EMPTY means no block is ready to read. DRAIN means a block is being emitted. The transitions are:
- EMPTY to DRAIN (take) on the cycle the 32nd bit is captured.
- DRAIN to DRAIN (refill) when the last bit of a block leaves on the same cycle a new block completes.
- DRAIN to EMPTY (starve) when the last bit leaves with no complete block waiting.
- DRAIN holds otherwise, and the read pointer advances on each cycle without a stall.

Top module: `pp_bit_reverser`

## Requirements
- R1: After reset, and until the first full block of 32 bits has been captured, `out_valid` is low.
- R2: Within each block, the bits appear on `out_bit` in the reverse of their capture order: the bit captured last is emitted first, and the bit captured first is emitted last.
- R3: When no block is being emitted, `out_valid` rises in the clock cycle right after the rising edge that captures the 32nd bit of a block.
- R4: Each completed block yields exactly 32 output cycles with `out_valid` high. With uninterrupted input and no stall, the output stays valid with no idle cycle between consecutive blocks.
- R5: While `stall` is high, `out_valid` is low and the read position holds. Once `stall` drops, the output resumes with the same bit that was due when the stall began.
- R6: Cycles with `in_valid` low capture nothing, so a block whose bits arrive with gaps is still reversed correctly. It is released only when its 32nd valid bit is captured.
- R7: A bit offered with `in_valid` high while `stall` is high is not captured and does not count toward the block.
- R8: When a block finishes draining and no new block is complete, `out_valid` goes low and stays low until the next block completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | Serial bit from the traceback, newest first |
| in_valid | input | 1 | `in_bit` is offered this cycle |
| stall | input | 1 | Downstream hold: freezes both pointers |
| out_bit | output | 1 | Serial bit in restored order, meaningful when `out_valid` is high |
| out_valid | output | 1 | `out_bit` carries a bit this cycle |

## Verification
The outputs are decoded from registered state, so they respond with no extra pipeline stage. The first bit of a block is due in the cycle right after the edge that captures its 32nd bit. Each further bit follows on the next cycle without a stall, and a stall pulls `out_valid` low in the same cycle it is raised. The bench changes inputs on the falling edge and compares both outputs 1 ns later against a queue model that updates on each rising edge, so every expectation falls in exactly the cycle named above. Separate checks cover the reset state, the total count of valid cycles across a continuous run, and the resumption bit after a stall.

// File: rtl/lrev_pkg.sv
package lrev_pkg;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_DRAIN = 1'b1
    } rd_state_e;

    function automatic int ptr_width(input int len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/lrev_wr_ctrl.sv
module lrev_wr_ctrl #(
    parameter int BLK_LEN = 32,
    localparam int PTR_W = lrev_pkg::ptr_width(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             stall,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic             blk_ready
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(BLK_LEN - 1);

    logic [PTR_W-1:0] wr_cnt;

    always_comb begin
        wr_en     = in_valid && !stall;
        wr_idx    = LAST - wr_cnt;
        blk_ready = wr_en && (wr_cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (wr_en) begin
            wr_cnt <= blk_ready ? '0 : wr_cnt + 1'b1;
        end
    end

    // R5 / R7: a stalled cycle leaves the write position untouched
    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(wr_cnt));

    // R6: an idle input cycle leaves the write position untouched
    assert_wr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_cnt));

endmodule

// File: rtl/lrev_rd_fsm.sv
module lrev_rd_fsm
    import lrev_pkg::*;
#(
    parameter int BLK_LEN = 32,
    localparam int PTR_W = lrev_pkg::ptr_width(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             blk_ready,
    output logic             swap,
    output logic [PTR_W-1:0] rd_idx,
    output logic             out_valid
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(BLK_LEN - 1);

    rd_state_e        state_q;
    rd_state_e        state_d;
    logic [PTR_W-1:0] rd_cnt;
    logic [PTR_W-1:0] rd_cnt_d;
    logic             rd_last;

    // next-state logic
    always_comb begin
        rd_last  = (state_q == RS_DRAIN) && !stall && (rd_cnt == LAST);
        swap     = blk_ready && ((state_q == RS_EMPTY) || rd_last);
        state_d  = state_q;
        rd_cnt_d = rd_cnt;
        unique case (state_q)
            RS_EMPTY: begin
                if (swap) begin
                    state_d  = RS_DRAIN;
                    rd_cnt_d = '0;
                end
            end
            RS_DRAIN: begin
                if (rd_last) begin
                    state_d  = swap ? RS_DRAIN : RS_EMPTY;
                    rd_cnt_d = '0;
                end else if (!stall) begin
                    rd_cnt_d = rd_cnt + 1'b1;
                end
            end
            default: begin
                state_d  = RS_EMPTY;
                rd_cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            rd_cnt  <= '0;
        end else begin
            state_q <= state_d;
            rd_cnt  <= rd_cnt_d;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == RS_DRAIN) && !stall;
        rd_idx    = rd_cnt;
    end

    // R5: a stall freezes the read position and the state
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(rd_cnt) && $stable(state_q)));

    // R4: a completed block always finds the read bank free
    assert_blk_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> swap);

    // R8: leaving DRAIN for EMPTY only happens after the last read position
    assert_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_DRAIN && state_d == RS_EMPTY) |-> (rd_cnt == LAST));

endmodule

// File: rtl/lrev_banks.sv
module lrev_banks #(
    parameter int BLK_LEN = 32,
    localparam int PTR_W = lrev_pkg::ptr_width(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic             swap,
    input  logic [PTR_W-1:0] rd_idx,
    output logic             rd_bit
);

    logic               wr_sel;
    logic               rd_sel;
    logic [BLK_LEN-1:0] bank_q [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sel <= 1'b0;
        end else if (swap) begin
            wr_sel <= !wr_sel;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && (wr_sel == g[0])) begin
                bank_q[g][wr_idx] <= wr_bit;
            end
        end
    end

    always_comb begin
        rd_sel = !wr_sel;
        rd_bit = bank_q[rd_sel][rd_idx];
    end

    // R2: the bank being read is never the one written in the same cycle
    assert_bank_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !swap) |=> $stable(bank_q[rd_sel]));

endmodule

// File: rtl/pp_bit_reverser.sv
module pp_bit_reverser #(
    parameter int BLK_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_valid,
    input  logic stall,
    output logic out_bit,
    output logic out_valid
);

    localparam int PTR_W = lrev_pkg::ptr_width(BLK_LEN);
    localparam int CNT_W = $clog2(BLK_LEN + 1);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic             blk_ready;
    logic             swap;
    logic [PTR_W-1:0] rd_idx;

    lrev_wr_ctrl #(.BLK_LEN(BLK_LEN)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .stall     (stall),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .blk_ready (blk_ready)
    );

    lrev_rd_fsm #(.BLK_LEN(BLK_LEN)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .blk_ready (blk_ready),
        .swap      (swap),
        .rd_idx    (rd_idx),
        .out_valid (out_valid)
    );

    lrev_banks #(.BLK_LEN(BLK_LEN)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (in_bit),
        .swap   (swap),
        .rd_idx (rd_idx),
        .rd_bit (out_bit)
    );

    // checker state: blocks released so far and bits emitted since the last swap
    logic             seen_block;
    logic [CNT_W-1:0] emit_cnt;
    logic [CNT_W-1:0] emit_total;

    always_comb emit_total = emit_cnt + {{(CNT_W-1){1'b0}}, out_valid};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_block <= 1'b0;
            emit_cnt   <= '0;
        end else begin
            if (swap) seen_block <= 1'b1;
            emit_cnt <= swap ? '0 : emit_total;
        end
    end

    // R1: nothing leaves before the first block is captured
    assert_quiet_before_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_block |-> !out_valid);

    // R4: every released block gives exactly BLK_LEN valid outputs before the next swap
    assert_full_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && seen_block) |-> (emit_total == CNT_W'(BLK_LEN)));

    // R3: a swap from an idle read side brings valid output on the next cycle
    assert_take_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !out_valid && !stall) |=> (out_valid || stall));

endmodule

// File: tb/pp_bit_reverser_test.sv
module pp_bit_reverser_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_bit = 1'b0;
    logic in_valid = 1'b0;
    logic stall = 1'b0;
    logic out_bit;
    logic out_valid;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    int   valid_seen = 0;
    logic wq[$];
    logic rq[$];
    int   lfsr = 32'h1ACE5;

    always #10 clk = ~clk;

    pp_bit_reverser #(.BLK_LEN(32)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_bit    (in_bit),
        .in_valid  (in_valid),
        .stall     (stall),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%0b exp=%0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 32'h0);
        return lfsr[0];
    endfunction

    // one clock cycle: drive, compare against the queue model, then advance the model
    task automatic step(input logic v, input logic b, input logic s, input string tag);
        logic exp_v;
        @(negedge clk);
        in_valid = v;
        in_bit   = b;
        stall    = s;
        #1;
        exp_v = (rq.size() > 0) && !s;
        check(tag, "out_valid", out_valid, exp_v);
        if (exp_v) check(tag, "out_bit", out_bit, rq[0]);
        if (out_valid) valid_seen++;
        @(posedge clk);
        if (!s) begin
            if (rq.size() > 0) void'(rq.pop_front());
            if (v) begin
                wq.push_back(b);
                if (wq.size() == 32) begin
                    if (rq.size() != 0) begin
                        failures++;
                        $display("FAIL R4 model overlap got=%0d exp=0", rq.size());
                    end
                    for (int i = 31; i >= 0; i--) rq.push_back(wq[i]);
                    wq.delete();
                end
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", out_valid, 1'b0);
        rst_n = 1'b1;
        idle(4, "R1");

        // R2 R3 R8: a single block, then a drain to empty
        for (int i = 0; i < 31; i++) step(1'b1, next_bit(), 1'b0, "R1");
        step(1'b1, next_bit(), 1'b0, "R3");
        idle(40, "R2 R8");

        // R4: four blocks back to back, with exactly 128 valid outputs
        valid_seen = 0;
        for (int i = 0; i < 128; i++) step(1'b1, next_bit(), 1'b0, "R4");
        idle(40, "R4");
        check("R4", "valid count == 128", logic'(valid_seen == 128), 1'b1);

        // R6: gaps in the input, valid every other cycle
        for (int i = 0; i < 64; i++) begin
            step(1'b1, next_bit(), 1'b0, "R6");
            step(1'b0, 1'b1, 1'b0, "R6");
        end
        idle(40, "R6");

        // R5 R7: stalls while draining, with bits offered during the stall
        for (int i = 0; i < 32; i++) step(1'b1, next_bit(), 1'b0, "R5");
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 2) step(1'b1, 1'b1, 1'b1, "R7");
            else if (i % 5 == 3) step(1'b1, 1'b0, 1'b1, "R5");
            else step(1'b1, next_bit(), 1'b0, "R5");
        end
        idle(60, "R5 R7");

        // R5: a long stall in mid-block, then resumption
        for (int i = 0; i < 32; i++) step(1'b1, next_bit(), 1'b0, "R5");
        idle(5, "R5");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1, "R5");
        idle(40, "R5 R8");

        done = 1'b1;
        finish_run();
    end

endmodule